// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block sits between a processor-side request port and a shared bus on which one set of lines carries both the address and the data. It accepts one fetch or store at a time through a valid/ready handshake and raises a bus request. After the grant arrives, it spends one cycle driving the address. A store then drives its data on the same lines until the responder signals completion. A fetch releases the lines and captures the value present on them when completion is signalled.

The bus request is dropped at the end of every transfer so that another unit can take the bus. A watchdog counts the cycles from the first request cycle onward. If completion has not arrived by the configured limit, the transfer is abandoned and the processor side receives an error response instead of data.

Top module: `mux_bus_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `req_ready` is 1 and `bus_req`, `bus_ad_oe`, `bus_addr_phase`, `bus_data_phase` and `rsp_valid` are 0. An asynchronous reset in the middle of a transfer returns the block to this state at once.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `bus_req` is 1 and `req_ready` is 0 until the response cycle.
- R3: The edge that first samples `bus_gnt` high while the bus is requested starts exactly one address cycle. In that cycle `bus_ad_out` carries the accepted address, `bus_ad_oe` and `bus_addr_phase` are 1, and `bus_write` is 1 for a store and 0 for a fetch.
- R4: For a store, every cycle after the address cycle drives the accepted store data on `bus_ad_out`, with `bus_ad_oe` and `bus_data_phase` both 1, until completion.
- R5: For a fetch, `bus_ad_oe` is 0 in every cycle after the address cycle. The value returned is the value on `bus_ad_in` in the cycle where `bus_done` is sampled high.
- R6: When `bus_done` is sampled high in a data cycle, the next cycle has `rsp_valid`=1, `rsp_err`=0, `bus_req`=0 and `req_ready`=1. A new request can be accepted in that same cycle.
- R7: Counting the first cycle with `bus_req` high as cycle 1, if completion is not sampled by the end of cycle TIMEOUT, the transfer ends with `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0 in cycle TIMEOUT+1, and the bus is released. `bus_req` is never high for more than TIMEOUT consecutive cycles.
- R8: Completion sampled at the end of cycle TIMEOUT takes precedence over the timeout, and the response is a success.
- R9: A grant that never arrives also ends in the timeout error of R7, and no address cycle occurs.
- R10: While a transfer is in progress, `req_valid` and changes on the request fields are ignored. `bus_done` has no effect in the request or address cycles.
- R11: `rsp_valid` is high for exactly one cycle per transfer, and `rsp_rdata` is 0 for stores and for errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | BUS_W | Transfer address |
| req_wdata | input | BUS_W | Store data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a timeout error |
| rsp_rdata | output | BUS_W | Fetched value (0 for store or error) |
| bus_req | output | 1 | Bus ownership request, held for the whole transfer |
| bus_gnt | input | 1 | Bus grant |
| bus_ad_out | output | BUS_W | Value driven onto the shared lines |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | BUS_W | Value present on the shared lines |
| bus_addr_phase | output | 1 | Address cycle marker |
| bus_data_phase | output | 1 | Store data cycle marker |
| bus_write | output | 1 | Direction of the current transfer |
| bus_done | input | 1 | Responder completion |

## Verification
Two events can coincide in this block. Completion can arrive on the very cycle the watchdog expires. A response can also go out in the same cycle that the next request is accepted. The first is provoked by delaying the grant and the completion so that `bus_done` lands exactly on cycle TIMEOUT, and it is judged by a clean response in cycle TIMEOUT+1. A second case delays the completion by one more cycle and must give an error. The second event is provoked by presenting every new request in the cycle its predecessor responds. Each transfer is then checked for a fresh request in the following cycle and for a response strobe that has already fallen.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_ADDR  = 3'd2,
      ST_WDATA = 3'd3,
      ST_RDATA = 3'd4
   } mbm_state_e;

endpackage

// File: rtl/mbm_timer.sv
module mbm_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = $clog2(TIMEOUT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // cnt holds (busy cycle index - 1); the last permitted cycle is TIMEOUT
   assign expire = run && (cnt == CW'(TIMEOUT - 1));

endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
   import mbm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic       wr_q,
   input  logic       bus_gnt,
   input  logic       bus_done,
   input  logic       expire,
   output mbm_state_e state,
   output logic       finish_ok,
   output logic       finish_err
);
   mbm_state_e nxt;

   always_comb begin
      nxt        = state;
      finish_ok  = 1'b0;
      finish_err = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (accept) nxt = ST_REQ;
         end
         ST_REQ: begin
            if (expire) begin
               nxt        = ST_IDLE;
               finish_err = 1'b1;
            end else if (bus_gnt) begin
               nxt = ST_ADDR;
            end
         end
         ST_ADDR: begin
            if (expire) begin
               nxt        = ST_IDLE;
               finish_err = 1'b1;
            end else begin
               nxt = wr_q ? ST_WDATA : ST_RDATA;
            end
         end
         ST_WDATA, ST_RDATA: begin
            // completion outranks an expiring watchdog in the same cycle
            if (bus_done) begin
               nxt       = ST_IDLE;
               finish_ok = 1'b1;
            end else if (expire) begin
               nxt        = ST_IDLE;
               finish_err = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= nxt;
   end

endmodule

// File: rtl/mbm_lane.sv
module mbm_lane
   import mbm_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             req_write,
   input  logic [BUS_W-1:0] req_addr,
   input  logic [BUS_W-1:0] req_wdata,
   input  mbm_state_e       state,
   input  logic             finish_ok,
   input  logic             finish_err,
   input  logic [BUS_W-1:0] bus_ad_in,
   output logic             wr_q,
   output logic [BUS_W-1:0] bus_ad_out,
   output logic             bus_ad_oe,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [BUS_W-1:0] rsp_rdata
);
   logic [BUS_W-1:0] addr_q;
   logic [BUS_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         wr_q   <= 1'b0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_wdata;
         wr_q   <= req_write;
      end
   end

   assign bus_ad_oe = (state == ST_ADDR) || (state == ST_WDATA);

   generate
      if (PARK_ZERO) begin : g_park_zero
         always_comb begin
            unique case (state)
               ST_ADDR:  bus_ad_out = addr_q;
               ST_WDATA: bus_ad_out = data_q;
               default:  bus_ad_out = '0;
            endcase
         end
      end else begin : g_park_hold
         assign bus_ad_out = (state == ST_WDATA) ? data_q : addr_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= finish_ok || finish_err;
         rsp_err   <= finish_err;
         if (finish_ok && !wr_q)
            rsp_rdata <= bus_ad_in;
         else if (finish_ok || finish_err)
            rsp_rdata <= '0;
      end
   end

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
   import mbm_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int TIMEOUT   = 16,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [BUS_W-1:0] req_addr,
   input  logic [BUS_W-1:0] req_wdata,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [BUS_W-1:0] rsp_rdata,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic [BUS_W-1:0] bus_ad_out,
   output logic             bus_ad_oe,
   input  logic [BUS_W-1:0] bus_ad_in,
   output logic             bus_addr_phase,
   output logic             bus_data_phase,
   output logic             bus_write,
   input  logic             bus_done
);
   generate
      if (BUS_W < 1) begin : g_bad_width
         $error("mux_bus_master: BUS_W must be at least 1");
      end
      if (TIMEOUT < 3) begin : g_bad_timeout
         $error("mux_bus_master: TIMEOUT must cover request, address and data cycles");
      end
   endgenerate

   mbm_state_e state;
   logic       accept;
   logic       wr_q;
   logic       expire;
   logic       finish_ok;
   logic       finish_err;

   assign req_ready      = (state == ST_IDLE);
   assign accept         = req_valid && req_ready;
   assign bus_req        = (state != ST_IDLE);
   assign bus_addr_phase = (state == ST_ADDR);
   assign bus_data_phase = (state == ST_WDATA);
   assign bus_write      = bus_req && wr_q;

   mbm_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (bus_req),
      .expire (expire)
   );

   mbm_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .wr_q       (wr_q),
      .bus_gnt    (bus_gnt),
      .bus_done   (bus_done),
      .expire     (expire),
      .state      (state),
      .finish_ok  (finish_ok),
      .finish_err (finish_err)
   );

   mbm_lane #(.BUS_W(BUS_W), .PARK_ZERO(PARK_ZERO)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .state      (state),
      .finish_ok  (finish_ok),
      .finish_err (finish_err),
      .bus_ad_in  (bus_ad_in),
      .wr_q       (wr_q),
      .bus_ad_out (bus_ad_out),
      .bus_ad_oe  (bus_ad_oe),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata)
   );

endmodule

// File: rtl/mbm_checks.sv
module mbm_checks #(
   parameter int TIMEOUT = 16
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic bus_req,
   input logic bus_gnt,
   input logic bus_ad_oe,
   input logic bus_addr_phase,
   input logic bus_data_phase,
   input logic bus_write,
   input logic rsp_valid
);
   localparam int CW = $clog2(TIMEOUT + 2);

   logic [CW-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= '0;
      else if (!bus_req)
         held <= '0;
      else if (held != {CW{1'b1}})
         held <= held + 1'b1;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (!bus_ad_oe && !bus_addr_phase && !bus_data_phase));

   assert_req_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(req_valid && req_ready));

   assert_addr_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_addr_phase) |-> $past(bus_gnt));

   assert_store_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_phase |-> (bus_write && bus_ad_oe && bus_req));

   assert_drive_only_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ad_oe |-> (bus_addr_phase || bus_data_phase));

   assert_rsp_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!bus_req && req_ready));

   assert_hold_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (held < CW'(TIMEOUT)));

   assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !req_ready);

   assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind mux_bus_master mbm_checks #(.TIMEOUT(TIMEOUT)) u_mbm_checks (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .bus_req        (bus_req),
   .bus_gnt        (bus_gnt),
   .bus_ad_oe      (bus_ad_oe),
   .bus_addr_phase (bus_addr_phase),
   .bus_data_phase (bus_data_phase),
   .bus_write      (bus_write),
   .rsp_valid      (rsp_valid)
);

// File: tb/mux_bus_master_test.sv
module mux_bus_master_test;
   localparam int W       = 32;
   localparam int TMO     = 16;
   localparam int CLK_PER = 10;

   typedef struct packed {
      logic        wr;
      logic        noise;
      logic [31:0] addr;
      logic [31:0] data;
      logic [7:0]  g;        // grant visible from busy cycle g+1
      logic [7:0]  dd;       // extra data cycles before completion
      logic        exp_err;
      logic [7:0]  exp_k;    // busy cycle index that shows the response
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 32'h0000_1000, 32'hCAFE_0001, 8'd0,  8'd0,  1'b0, 8'd4},  // R4 store, fast
      '{1'b0, 1'b0, 32'h0000_2004, 32'hA5A5_5A5A, 8'd0,  8'd0,  1'b0, 8'd4},  // R5 fetch, fast
      '{1'b0, 1'b0, 32'h0020_000C, 32'h1234_5678, 8'd2,  8'd3,  1'b0, 8'd9},  // R5 fetch, delays
      '{1'b1, 1'b1, 32'h00FF_0010, 32'h0BAD_F00D, 8'd1,  8'd5,  1'b0, 8'd10}, // R10 store with noise
      '{1'b0, 1'b1, 32'h0100_0000, 32'hDEAD_BEEF, 8'd3,  8'd2,  1'b0, 8'd9},  // R10 fetch with noise
      '{1'b0, 1'b0, 32'h0000_0040, 32'h7777_0001, 8'd4,  8'd9,  1'b0, 8'd17}, // R8 done on last cycle
      '{1'b1, 1'b0, 32'h0000_0080, 32'h3333_4444, 8'd4,  8'd10, 1'b1, 8'd17}, // R7 one cycle late
      '{1'b0, 1'b0, 32'h0000_00C0, 32'h5555_6666, 8'd20, 8'd0,  1'b1, 8'd17}, // R9 grant never comes
      '{1'b0, 1'b0, 32'h0000_0100, 32'h9999_AAAA, 8'd0,  8'd20, 1'b1, 8'd17}  // R7 fetch timeout
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [W-1:0]  req_addr = '0;
   logic [W-1:0]  req_wdata = '0;
   logic          rsp_valid;
   logic          rsp_err;
   logic [W-1:0]  rsp_rdata;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [W-1:0]  bus_ad_out;
   logic          bus_ad_oe;
   logic [W-1:0]  bus_ad_in = '0;
   logic          bus_addr_phase;
   logic          bus_data_phase;
   logic          bus_write;
   logic          bus_done = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #(CLK_PER/2) clk = ~clk;

   mux_bus_master #(.BUS_W(W), .TIMEOUT(TMO)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_write      (req_write),
      .req_addr       (req_addr),
      .req_wdata      (req_wdata),
      .rsp_valid      (rsp_valid),
      .rsp_err        (rsp_err),
      .rsp_rdata      (rsp_rdata),
      .bus_req        (bus_req),
      .bus_gnt        (bus_gnt),
      .bus_ad_out     (bus_ad_out),
      .bus_ad_oe      (bus_ad_oe),
      .bus_ad_in      (bus_ad_in),
      .bus_addr_phase (bus_addr_phase),
      .bus_data_phase (bus_data_phase),
      .bus_write      (bus_write),
      .bus_done       (bus_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic string rsp_tag(input int i, input logic e);
      if (i == 5) return "R8";
      if (i == 7) return "R9";
      return e ? "R7" : "R6";
   endfunction

   task automatic idle_check(input string tag);
      chk(req_ready && !bus_req && !bus_ad_oe && !bus_addr_phase && !bus_data_phase && !rsp_valid,
          tag, {58'd0, req_ready, bus_req, bus_ad_oe, bus_addr_phase, bus_data_phase, rsp_valid},
          64'b100000);
   endtask

   // entered and left at a falling edge; the next transfer is offered in the response cycle
   task automatic run_vec(input int i);
      vec_t v;
      int   kd;
      logic [W-1:0] exp_rd;
      v  = VECS[i];
      kd = int'(v.g) + 3 + int'(v.dd);
      chk(req_ready, "R6 ready before offer", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1;
      req_write = v.wr;
      req_addr  = v.addr;
      req_wdata = v.data;
      bus_gnt   = 1'b0;
      bus_done  = 1'b0;
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         if (k == int'(v.exp_k)) begin
            exp_rd = (v.wr || v.exp_err) ? '0 : v.data;
            chk(rsp_valid && (rsp_err == v.exp_err), rsp_tag(i, v.exp_err),
                {62'd0, rsp_valid, rsp_err}, {62'd0, 1'b1, v.exp_err});
            chk(rsp_rdata == exp_rd, "R11 R5 rdata", 64'(rsp_rdata), 64'(exp_rd));
            chk(!bus_req && req_ready, "R6 released", {62'd0, bus_req, req_ready}, 64'b01);
            req_valid = 1'b0;
            bus_gnt   = 1'b0;
            bus_done  = 1'b0;
            return;
         end
         chk(bus_req && !req_ready && !rsp_valid, "R2 R11 busy",
             {61'd0, bus_req, req_ready, rsp_valid}, 64'b100);
         if (k == int'(v.g) + 2)
            chk(bus_addr_phase && bus_ad_oe && bus_ad_out == v.addr && bus_write == v.wr,
                "R3 R10 address cycle", {bus_ad_out, 29'd0, bus_addr_phase, bus_ad_oe, bus_write},
                {v.addr, 29'd0, 1'b1, 1'b1, v.wr});
         if (k == int'(v.g) + 3) begin
            if (v.wr)
               chk(bus_data_phase && bus_ad_oe && bus_ad_out == v.data, "R4 store data",
                   {bus_ad_out, 30'd0, bus_data_phase, bus_ad_oe}, {v.data, 30'd0, 2'b11});
            else
               chk(!bus_data_phase && !bus_ad_oe && !bus_addr_phase, "R5 lines released",
                   {61'd0, bus_data_phase, bus_ad_oe, bus_addr_phase}, 64'd0);
         end
         req_valid = v.noise && (k <= int'(v.g) + 2);
         req_write = ~v.wr;
         req_addr  = ~v.addr;
         req_wdata = ~v.data;
         bus_gnt   = (k > int'(v.g));
         bus_done  = (k == kd) || (v.noise && (k < int'(v.g) + 3));
         bus_ad_in = (k == kd) ? v.data : ~v.data;
      end
      chk(1'b0, "R6 no response", 64'd0, 64'd1);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: state held in reset and after release
      repeat (3) @(negedge clk);
      idle_check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1 after release");

      for (int i = 0; i < NV; i++) run_vec(i);

      @(negedge clk);
      chk(!rsp_valid && req_ready, "R11 strobe falls", {62'd0, rsp_valid, req_ready}, 64'b01);

      // R1: asynchronous reset during an address cycle
      req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0500;
      @(negedge clk);
      req_valid = 1'b0; bus_gnt = 1'b1;
      @(negedge clk);
      chk(bus_addr_phase, "R3 address before reset", {63'd0, bus_addr_phase}, 64'd1);
      rst_n = 1'b0;
      #1;
      idle_check("R1 async reset");
      bus_gnt = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1 idle after mid reset");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule